// File: doc/BRIEF.md
# Flash Row Write Sequencer

This block drives writes into an on-chip program flash. Software loads a 64-byte holding buffer one byte at a time: a table pointer picks the buffer slot with its low six bits and moves on to the next slot after each byte. The upper pointer bits pick the target row. Loading the buffer never touches the array. A write or erase starts only from the control register, and only after a two-byte key has reached the unlock register immediately before the start request.

Once a start is accepted, the sequencer raises the CPU stall line for a fixed number of clock cycles. That count is a parameter and must be at least the row size. In the first cycles of that window it emits one byte-program strobe per buffer slot, or a single block-erase strobe. A timer ends the window and a one-cycle done pulse follows. The array model applies a program strobe as old AND new, so programming only clears bits. An erase strobe sets a whole 1024-byte block to FFh. The buffer keeps its contents after a cycle, so software must overwrite it before the next pass.

Top module: `fsq_row_writer`

## Requirements
- R1: After reset, `ptr_o` is 0, `ctl_o` is 00h, and `stall_o`, `done_o`, `fl_prog_o` and `fl_erase_o` are low.
- R2: A write with `cpu_sel_i`=0 stores the byte in holding slot `ptr_o[5:0]`. It then increments `ptr_o[5:0]` modulo 64 and leaves the upper pointer bits unchanged.
- R3: Buffer writes, pointer loads and control or key writes never raise `fl_prog_o` or `fl_erase_o` outside a started cycle.
- R4: A control write (`cpu_sel_i`=1) with bit 1 (start) and bit 2 (write enable) both set starts a cycle only when the two writes just before it were key writes (`cpu_sel_i`=2) of 55h and then AAh. A started cycle holds `stall_o` high for exactly WR_CYCLES cycles, and `ctl_o[1]` reads 1 during it. `done_o` pulses for one cycle as `stall_o` falls.
- R5: A start request that is refused leaves `stall_o` low and `ctl_o[1]` at 0, and sets the sticky error bit `ctl_o[3]`. A later control write with bit 3 set clears the error bit, unless that write is itself a refused start.
- R6: Any other write between 55h, AAh and the start request breaks the key. This includes a pointer load or a write with `cpu_sel_i`=3, and the start request that follows is then refused.
- R7: When `ctl_o[4]` (erase select, written from control bit 4) is 0, a cycle emits 64 program strobes on consecutive cycles from its first stalled cycle. Strobe i carries address {pointer row, i} and holding slot i. The array then holds old AND new.
- R8: When erase select is 1, a cycle emits exactly one `fl_erase_o` strobe, on its first stalled cycle, with the pointer rounded down to a 1024-byte boundary, and no program strobes.
- R9: Holding slots keep their contents across a completed cycle.
- R10: While `stall_o` is high, buffer, pointer, control and key writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU register write strobe |
| cpu_sel_i | input | 2 | Target: 0 holding buffer, 1 control, 2 key, 3 reserved |
| cpu_wdata_i | input | 8 | Write data |
| ptr_ld_i | input | 1 | Load the table pointer |
| ptr_val_i | input | ADDR_W | Value for pointer load |
| ptr_o | output | ADDR_W | Current table pointer |
| ctl_o | output | 8 | Control readback: bit1 busy/start, bit2 write enable, bit3 error, bit4 erase select |
| stall_o | output | 1 | CPU stall, high for the whole timed cycle |
| done_o | output | 1 | One-cycle pulse at the end of a cycle |
| fl_prog_o | output | 1 | Byte program strobe to the array |
| fl_erase_o | output | 1 | Block erase strobe to the array |
| fl_addr_o | output | ADDR_W | Array byte address for the current strobe |
| fl_wdata_o | output | 8 | Program data for the current strobe |

## Verification
A key tracker left in the wrong state either starts a cycle that should be refused or refuses one that should start. Either fault shows on `stall_o` and `ctl_o[3]` on the cycle after the start write. A wrong slot index or a stale row base shows up on the first wrong program strobe: a scoreboard checks each strobe's address and data as it appears. A timer that is off by one changes the measured stall length and the timing of `done_o`. A buffer or pointer that changes during a stall shows in the strobes later in the same cycle and in `ptr_o` once the stall ends.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_KEY  = 2'd2,
        SEL_RSVD = 2'd3
    } cpu_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CTL_START = 1;
    localparam int CTL_WEN   = 2;
    localparam int CTL_ERR   = 3;
    localparam int CTL_ERASE = 4;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_ONE  = 2'd1,
        UL_TWO  = 2'd2
    } unlock_e;
endpackage

// File: rtl/fsq_unlock.sv
`timescale 1ns/1ps
module fsq_unlock
    import fsq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic       key_i,
    input  logic [7:0] data_i,
    output logic       armed_o
);
    typedef struct packed {
        unlock_e st;
    } ul_t;

    ul_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (key_i && data_i == KEY_FIRST) begin
                st_d.st = UL_ONE;
            end else if (key_i && data_i == KEY_SECOND && st_q.st == UL_ONE) begin
                st_d.st = UL_TWO;
            end else begin
                st_d.st = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{st: UL_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = (st_q.st == UL_TWO);
endmodule

// File: rtl/fsq_hold_buf.sv
`timescale 1ns/1ps
module fsq_hold_buf #(
    parameter int ROW_BYTES = 64,
    localparam int IDX_W = $clog2(ROW_BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o
);
    logic [ROW_BYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/fsq_cycle.sv
`timescale 1ns/1ps
module fsq_cycle #(
    parameter int ADDR_W    = 16,
    parameter int ROW_BYTES = 64,
    parameter int BLK_BYTES = 1024,
    parameter int WR_CYCLES = 64,
    localparam int ROW_W = $clog2(ROW_BYTES),
    localparam int BLK_W = $clog2(BLK_BYTES),
    localparam int TMR_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              prog_o,
    output logic              erase_o,
    output logic [ROW_W-1:0]  rd_idx_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ROW_MASK = ADDR_W'(ROW_BYTES - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(BLK_BYTES - 1);
    localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(WR_CYCLES - 1);
    localparam logic [ROW_W:0]    IDX_END  = (ROW_W+1)'(ROW_BYTES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              is_erase;
        logic [ADDR_W-1:0] base;
        logic [ROW_W:0]    idx;
        logic [TMR_W-1:0]  tmr;
    } cyc_t;

    cyc_t s_d, s_q;
    logic active;

    assign active = s_q.busy && !s_q.idx[ROW_W];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy     = 1'b1;
                s_d.is_erase = erase_i;
                s_d.base     = erase_i ? (ptr_i & ~BLK_MASK) : (ptr_i & ~ROW_MASK);
                s_d.idx      = '0;
                s_d.tmr      = TMR_LAST;
            end
        end else begin
            if (!s_q.idx[ROW_W]) begin
                s_d.idx = s_q.is_erase ? IDX_END : s_q.idx + 1'b1;
            end
            if (s_q.tmr == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.tmr = s_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = s_q.busy;
    assign done_o   = s_q.done;
    assign prog_o   = active && !s_q.is_erase;
    assign erase_o  = active && s_q.is_erase;
    assign rd_idx_o = s_q.idx[ROW_W-1:0];
    assign addr_o   = s_q.base | ADDR_W'(s_q.idx[ROW_W-1:0]);
endmodule

// File: rtl/fsq_row_writer.sv
`timescale 1ns/1ps
module fsq_row_writer
    import fsq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROW_BYTES = 64,
    parameter int BLK_BYTES = 1024,
    parameter int WR_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpu_wr_i,
    input  logic [1:0]        cpu_sel_i,
    input  logic [7:0]        cpu_wdata_i,
    input  logic              ptr_ld_i,
    input  logic [ADDR_W-1:0] ptr_val_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [7:0]        ctl_o,
    output logic              stall_o,
    output logic              done_o,
    output logic              fl_prog_o,
    output logic              fl_erase_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_wdata_o
);
    localparam int ROW_W = $clog2(ROW_BYTES);
    localparam int BLK_W = $clog2(BLK_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              wen;
        logic              erase_sel;
        logic              err;
    } top_t;

    top_t r_d, r_q;

    cpu_sel_e   sel;
    logic       busy;
    logic       wr_ok, ld_ok;
    logic       hold_we, ctl_we, key_we;
    logic       armed, start;
    logic [ROW_W-1:0] rd_idx;

    assign sel     = cpu_sel_e'(cpu_sel_i);
    assign wr_ok   = cpu_wr_i && !busy;
    assign ld_ok   = ptr_ld_i && !busy;
    assign hold_we = wr_ok && sel == SEL_HOLD;
    assign ctl_we  = wr_ok && sel == SEL_CTRL;
    assign key_we  = wr_ok && sel == SEL_KEY;
    assign start   = ctl_we && cpu_wdata_i[CTL_START] && cpu_wdata_i[CTL_WEN] && armed;

    always_comb begin
        r_d = r_q;
        if (ld_ok) begin
            r_d.ptr = ptr_val_i;
        end else if (hold_we) begin
            r_d.ptr = {r_q.ptr[ADDR_W-1:ROW_W], r_q.ptr[ROW_W-1:0] + 1'b1};
        end
        if (ctl_we) begin
            r_d.wen       = cpu_wdata_i[CTL_WEN];
            r_d.erase_sel = cpu_wdata_i[CTL_ERASE];
            if (cpu_wdata_i[CTL_ERR]) begin
                r_d.err = 1'b0;
            end
            if (cpu_wdata_i[CTL_START] && !start) begin
                r_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    fsq_unlock u_unlock (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_ok || ld_ok),
        .key_i   (key_we),
        .data_i  (cpu_wdata_i),
        .armed_o (armed)
    );

    fsq_hold_buf #(.ROW_BYTES(ROW_BYTES)) u_buf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (hold_we),
        .wr_idx_i  (r_q.ptr[ROW_W-1:0]),
        .wr_data_i (cpu_wdata_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (fl_wdata_o)
    );

    fsq_cycle #(
        .ADDR_W    (ADDR_W),
        .ROW_BYTES (ROW_BYTES),
        .BLK_BYTES (BLK_BYTES),
        .WR_CYCLES (WR_CYCLES)
    ) u_cycle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .erase_i  (cpu_wdata_i[CTL_ERASE]),
        .ptr_i    (r_q.ptr),
        .busy_o   (busy),
        .done_o   (done_o),
        .prog_o   (fl_prog_o),
        .erase_o  (fl_erase_o),
        .rd_idx_o (rd_idx),
        .addr_o   (fl_addr_o)
    );

    assign ptr_o   = r_q.ptr;
    assign stall_o = busy;
    assign ctl_o   = {3'b000, r_q.erase_sel, r_q.err, r_q.wen, busy, 1'b0};
endmodule

// File: rtl/fsq_row_writer_chk.sv
`timescale 1ns/1ps
module fsq_row_writer_chk #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_wr_i,
    input logic [ADDR_W-1:0] ptr_o,
    input logic              err_i,
    input logic              stall_o,
    input logic              done_o,
    input logic              fl_prog_o,
    input logic              fl_erase_o,
    input logic [BLK_W-1:0]  blk_off_i
);
    // R4: a stall begins only after a control write carrying start and write enable
    assert_stall_needs_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stall_o) |-> $past(start_wr_i));

    // R4: done marks the cycle right after the stall ends
    assert_done_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(stall_o) && !stall_o));

    // R5: the error flag never rises together with a started cycle
    assert_err_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_i) |-> !stall_o);

    // R7: program strobes only inside a stall
    assert_prog_in_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fl_prog_o || fl_erase_o) |-> stall_o);

    // R8: erase and program are exclusive, and erase addresses are block aligned
    assert_erase_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fl_erase_o |-> (!fl_prog_o && blk_off_i == '0));

    // R10: pointer frozen across a stalled edge
    assert_ptr_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(stall_o) |-> $stable(ptr_o));
endmodule

bind fsq_row_writer fsq_row_writer_chk #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (cpu_wr_i && cpu_sel_i == 2'd1 && cpu_wdata_i[1] && cpu_wdata_i[2]),
    .ptr_o      (ptr_o),
    .err_i      (ctl_o[3]),
    .stall_o    (stall_o),
    .done_o     (done_o),
    .fl_prog_o  (fl_prog_o),
    .fl_erase_o (fl_erase_o),
    .blk_off_i  (fl_addr_o[BLK_W-1:0])
);

// File: tb/tb_fsq_row_writer.sv
`timescale 1ns/1ps
module tb_fsq_row_writer;
    localparam int AW = 16;
    localparam int NCYC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [1:0]    cpu_sel = 2'd0;
    logic [7:0]    cpu_wdata = 8'h00;
    logic          ptr_ld = 1'b0;
    logic [AW-1:0] ptr_val = '0;
    logic [AW-1:0] ptr_o;
    logic [7:0]    ctl_o;
    logic          stall_o, done_o, fl_prog_o, fl_erase_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o;

    always #2.5 clk = ~clk;

    fsq_row_writer #(.ADDR_W(AW), .WR_CYCLES(NCYC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cpu_wr_i(cpu_wr), .cpu_sel_i(cpu_sel),
        .cpu_wdata_i(cpu_wdata), .ptr_ld_i(ptr_ld), .ptr_val_i(ptr_val),
        .ptr_o(ptr_o), .ctl_o(ctl_o), .stall_o(stall_o), .done_o(done_o),
        .fl_prog_o(fl_prog_o), .fl_erase_o(fl_erase_o),
        .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o)
    );

    typedef struct { bit er; int addr; int data; } item_t;
    item_t      expq[$];
    bit [7:0]   mem [int];
    bit [7:0]   hb [64];
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;

    function automatic bit [7:0] rd(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compare each strobe against the scoreboard queue, then update the array model
    always @(negedge clk) begin
        if (rst_n && (fl_prog_o || fl_erase_o)) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3 unexpected strobe: actual=%0h expected=none", fl_addr_o);
            end else begin
                item_t it;
                it = expq.pop_front();
                check(it.er ? "R8" : "R7", int'(fl_erase_o), int'(it.er), "strobe kind");
                check(it.er ? "R8" : "R7", int'(fl_addr_o), it.addr, "strobe addr");
                if (!it.er) check("R9", int'(fl_wdata_o), it.data, "strobe data");
            end
            if (fl_erase_o) begin
                for (int a = int'(fl_addr_o); a < int'(fl_addr_o) + 1024; a++)
                    if (mem.exists(a)) mem.delete(a);
            end else begin
                mem[int'(fl_addr_o)] = rd(int'(fl_addr_o)) & fl_wdata_o;
            end
        end
    end

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic hold_write(input logic [7:0] d);
        hb[ptr_o[5:0]] = d;
        cpu_write(2'd0, d);
    endtask

    task automatic load_ptr(input logic [AW-1:0] v);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_val = v;
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic push_row(input int base);
        for (int i = 0; i < 64; i++) begin
            item_t it;
            it.er = 0; it.addr = base + i; it.data = int'(hb[i]);
            expq.push_back(it);
        end
    endtask

    task automatic push_erase(input int base);
        item_t it;
        it.er = 1; it.addr = base; it.data = 0;
        expq.push_back(it);
    endtask

    task automatic unlock();
        cpu_write(2'd2, 8'h55);
        cpu_write(2'd2, 8'hAA);
    endtask

    // after the start write: measure stall length and the done pulse
    task automatic wait_cycle(string req);
        int c = 0;
        check(req, int'(ctl_o[1]), 1, "start bit during cycle");
        while (stall_o) begin
            c++;
            @(negedge clk);
        end
        check(req, c, NCYC, "stall length");
        check(req, int'(done_o), 1, "done pulse");
        @(negedge clk);
        check(req, int'(done_o), 0, "done one cycle");
        check("R7", expq.size(), 0, "strobes left");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all R): actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(ptr_o), 0, "ptr after reset");
        check("R1", int'(ctl_o), 0, "ctl after reset");
        check("R1", int'(stall_o), 0, "stall after reset");
        check("R1", int'(done_o), 0, "done after reset");

        // R2: slot write and wrap of low pointer bits
        load_ptr(16'h123E);
        hold_write(8'hA0);
        check("R2", int'(ptr_o), 16'h123F, "ptr increment");
        hold_write(8'hA1);
        hold_write(8'hA2);
        check("R2", int'(ptr_o), 16'h1201, "ptr wrap keeps row");

        load_ptr(16'h1240);
        for (int i = 0; i < 64; i++) hold_write(8'(i) ^ 8'h5A);
        check("R2", int'(ptr_o), 16'h1240, "ptr after full row");

        // R4: accepted program cycle
        cpu_write(2'd1, 8'h04);
        check("R4", int'(ctl_o), 8'h04, "wen readback");
        unlock();
        push_row(16'h1240);
        cpu_write(2'd1, 8'h06);
        wait_cycle("R4");
        check("R4", int'(ctl_o), 8'h04, "start self-clears");
        check("R7", int'(rd(16'h1240)), 8'h5A, "array byte 0");
        check("R7", int'(rd(16'h127F)), 8'h65, "array byte 63");

        // R5: refused start without key
        cpu_write(2'd1, 8'h06);
        check("R5", int'(stall_o), 0, "no stall on refusal");
        check("R5", int'(ctl_o), 8'h0C, "error set, start clear");
        repeat (3) @(negedge clk);
        check("R5", int'(ctl_o[3]), 1, "error sticky");
        cpu_write(2'd1, 8'h0C);
        check("R5", int'(ctl_o), 8'h04, "error cleared");

        // R6: pointer load between keys
        cpu_write(2'd2, 8'h55);
        load_ptr(16'h1240);
        cpu_write(2'd2, 8'hAA);
        cpu_write(2'd1, 8'h06);
        check("R6", int'(stall_o), 0, "broken by ptr load");
        check("R6", int'(ctl_o), 8'h0C, "error after ptr load break");
        cpu_write(2'd1, 8'h0C);
        // R6: reserved write between key and start
        unlock();
        cpu_write(2'd3, 8'h00);
        cpu_write(2'd1, 8'h06);
        check("R6", int'(stall_o), 0, "broken by reserved write");
        check("R6", int'(ctl_o[3]), 1, "error after reserved write");
        cpu_write(2'd1, 8'h0C);
        // R4: correct key but write enable clear
        unlock();
        cpu_write(2'd1, 8'h02);
        check("R4", int'(stall_o), 0, "no start without wen");
        check("R4", int'(ctl_o), 8'h08, "wen clear refusal");
        cpu_write(2'd1, 8'h0C);

        // R7 and R9: AND semantics, buffer retained
        load_ptr(16'h1240);
        hold_write(8'h0F);
        unlock();
        push_row(16'h1240);
        cpu_write(2'd1, 8'h06);
        wait_cycle("R7");
        check("R7", int'(rd(16'h1240)), 8'h0A, "AND of old and new");
        check("R9", int'(rd(16'h1241)), 8'h5B, "retained slot 1");

        // R8: block erase
        unlock();
        push_erase(16'h1000);
        cpu_write(2'd1, 8'h16);
        wait_cycle("R8");
        check("R8", int'(rd(16'h1240)), 8'hFF, "erased byte");
        check("R8", int'(ctl_o), 8'h14, "erase select readback");

        // R10: writes during stall are ignored
        cpu_write(2'd1, 8'h04);
        unlock();
        push_row(16'h1240);
        cpu_write(2'd1, 8'h06);
        load_ptr(16'h2000);
        cpu_write(2'd0, 8'h00);
        cpu_write(2'd1, 8'h1C);
        cpu_write(2'd2, 8'h55);
        while (stall_o) @(negedge clk);
        check("R10", int'(ptr_o), 16'h1241, "ptr unchanged by stalled writes");
        check("R10", int'(ctl_o), 8'h04, "ctl unchanged by stalled writes");
        @(negedge clk);
        check("R10", expq.size(), 0, "all strobes seen");
        cpu_write(2'd1, 8'h06);
        check("R10", int'(stall_o), 0, "stalled key write not kept");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule